// File: doc/BRIEF.md
# Grouped Carry-Lookahead Adder

This block adds two unsigned 16-bit operands and a one-bit carry-in, producing a 16-bit sum and a carry-out. The operand width is cut into four 4-bit slices. Inside a slice, every bit carry is formed in one level of lookahead logic from the slice's incoming carry and the per-bit propagate and generate terms. Between slices the carry ripples. This keeps the lookahead logic at a fixed, small size while the critical path grows only by one slice per extra nibble.

Two build variants are selected by a parameter. The combinational variant returns the result in the same cycle. The registered variant puts each slice into its own pipeline stage and delays that slice's operands until its incoming carry is ready. The slice carries therefore settle in step rather than racing one another. Sum bits are re-aligned at the output, and a valid flag travels alongside each operand pair. When the adder is the first stage of a chain, the carry-in is simply driven low.

Top module: `grouped_cla_adder`

## Requirements
- R1: With a valid input, {carry_out, sum} equals op_a + op_b + carry_in computed as a 17-bit unsigned value, for any operands.
- R2: carry_out is 1 exactly when the unsigned total exceeds 16'hFFFF (for example 16'h8000 + 16'h8000 gives sum 0 and carry_out 1).
- R3: 16'hFFFF + 16'h0000 with carry_in 1 propagates through all four slices and gives sum 16'h0000 with carry_out 1.
- R4: 16'h0000 + 16'h0000 with carry_in 0 gives sum 16'h0000 and carry_out 0.
- R5: A carry produced in one slice reaches the next slice (16'h000F + 16'h0001 = 16'h0010, 16'h0FFF + 16'h0001 = 16'h1000, 16'h00FF + 16'h0001 = 16'h0100).
- R6: In the registered variant (default), the result and out_valid appear exactly NUM_GROUPS (4) clock edges after the edge that samples in_valid high. Inputs may arrive on consecutive cycles, and each accepted input produces exactly one output, in order.
- R7: A synchronous active-low reset clears out_valid, sum and carry_out at the next edge. Operand pairs still in flight are dropped and never appear.
- R8: Cycles with in_valid low produce no out_valid, whatever the operands and carry_in carry on those cycles.
- R9: carry_in is added at the least significant bit (16'h0000 + 16'h0000 with carry_in 1 gives 16'h0001).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the registered variant |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Marks op_a, op_b and carry_in as a pair to add |
| op_a | input | 16 | First unsigned operand |
| op_b | input | 16 | Second unsigned operand |
| carry_in | input | 1 | Carry added at bit 0; tie low when unused |
| sum | output | 16 | Low 16 bits of the total |
| carry_out | output | 1 | Carry out of the top slice, the unsigned overflow flag |
| out_valid | output | 1 | Marks sum and carry_out as a result |

## Verification
The case that matters most is two operand pairs being processed in the same cycle. One pair's carry is crossing from one slice stage into the next while a newer pair is entering a lower stage. Any mix-up in the per-slice operand delays would then attach one pair's carry to the other pair's bits. The bench provokes this by issuing full-propagation and slice-boundary operands back to back, with pseudo-random pairs, idle gaps with junk operands, and a reset while pairs are in flight mixed in. A scoreboard judges each result against the arithmetic total, the issue order and the exact edge count since issue.

// File: rtl/gcla_pkg.sv
// Shared helpers for the grouped carry-lookahead adder.
// Assumes: the latency is counted in clock edges after the sampling edge.
package gcla_pkg;

    // Edges from the input-sampling edge to the result for a build variant.
    function automatic int unsigned gcla_latency(input bit registered,
                                                 input int unsigned groups);
        return registered ? groups : 0;
    endfunction

endpackage

// File: rtl/gcla_pfa.sv
// Partial full adder: one bit slice that emits propagate, generate and sum.
// Assumes: the carry for this bit is supplied by external lookahead logic.
module gcla_pfa (
    input  logic a,
    input  logic b,
    input  logic c,
    output logic p,
    output logic g,
    output logic s
);

    // Per-bit propagate, generate and sum terms.
    always_comb begin
        p = a ^ b;
        g = a & b;
        s = a ^ b ^ c;
    end

endmodule

// File: rtl/gcla_group.sv
// One lookahead slice: GW partial full adders plus a flat carry network.
// Each bit carry is a sum of products over the slice carry-in and the
// propagate/generate terms below it; no carry passes bit to bit.
// Assumes: GW is small (4 by default), so the product terms stay shallow.
module gcla_group #(
    parameter int unsigned GW = 4
) (
    input  logic [GW-1:0] a,
    input  logic [GW-1:0] b,
    input  logic          cin,
    output logic [GW-1:0] s,
    output logic          cout
);

    logic [GW-1:0] p_v;
    logic [GW-1:0] g_v;
    logic [GW:0]   carry_v;

    // Bit slices.
    for (genvar i = 0; i < GW; i++) begin : g_bit
        gcla_pfa u_pfa (
            .a (a[i]),
            .b (b[i]),
            .c (carry_v[i]),
            .p (p_v[i]),
            .g (g_v[i]),
            .s (s[i])
        );
    end

    // Flat lookahead: carry k = OR over sources j of (source j AND all P above j).
    always_comb begin
        carry_v = '0;
        carry_v[0] = cin;
        for (int k = 1; k <= GW; k++) begin
            logic acc;
            acc = cin;
            for (int m = 0; m < k; m++) acc = acc & p_v[m];
            for (int j = 0; j < k; j++) begin
                logic term;
                term = g_v[j];
                for (int m = j + 1; m < k; m++) term = term & p_v[m];
                acc = acc | term;
            end
            carry_v[k] = acc;
        end
    end

    assign cout = carry_v[GW];

endmodule

// File: rtl/gcla_delay.sv
// Fixed-depth register chain used to align operands, carries and sums.
// Assumes: DEPTH 0 is a plain wire; registers clear on synchronous reset.
module gcla_delay #(
    parameter int unsigned W     = 1,
    parameter int unsigned DEPTH = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    if (DEPTH == 0) begin : g_wire
        assign q = d;
    end else begin : g_regs
        logic [W-1:0] stage_q [DEPTH];

        // Shift the chain by one stage per clock; clear on reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int i = 0; i < DEPTH; i++) stage_q[i] <= '0;
            end else begin
                stage_q[0] <= d;
                for (int i = 1; i < DEPTH; i++) stage_q[i] <= stage_q[i-1];
            end
        end

        assign q = stage_q[DEPTH-1];
    end

endmodule

// File: rtl/grouped_cla_adder.sv
// Unsigned adder built from NUM_GROUPS lookahead slices of GROUP_W bits
// whose carries ripple from slice to slice.
// REGISTERED=1: slice g works in pipeline stage g; its operands are delayed
// g+1 edges so they meet the registered carry of slice g-1, and its sum is
// delayed to the common output edge. REGISTERED=0: purely combinational.
// Assumes: carry_in is tied low when the adder heads a chain.
module grouped_cla_adder
    import gcla_pkg::*;
#(
    parameter int unsigned GROUP_W    = 4,
    parameter int unsigned NUM_GROUPS = 4,
    parameter bit          REGISTERED = 1'b1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    input  logic [GROUP_W*NUM_GROUPS-1:0] op_a,
    input  logic [GROUP_W*NUM_GROUPS-1:0] op_b,
    input  logic                          carry_in,
    output logic [GROUP_W*NUM_GROUPS-1:0] sum,
    output logic                          carry_out,
    output logic                          out_valid
);

    localparam int unsigned WIDTH = GROUP_W * NUM_GROUPS;
    localparam int unsigned LAT   = gcla_latency(REGISTERED, NUM_GROUPS);

    logic [GROUP_W-1:0]    grp_a [NUM_GROUPS];
    logic [GROUP_W-1:0]    grp_b [NUM_GROUPS];
    logic [GROUP_W-1:0]    grp_s [NUM_GROUPS];
    logic [NUM_GROUPS-1:0] grp_cin;
    logic [NUM_GROUPS-1:0] grp_cout;

    // Lookahead slices, identical in both variants.
    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_slice
        gcla_group #(.GW(GROUP_W)) u_group (
            .a    (grp_a[g]),
            .b    (grp_b[g]),
            .cin  (grp_cin[g]),
            .s    (grp_s[g]),
            .cout (grp_cout[g])
        );
    end

    if (REGISTERED) begin : g_pipe
        for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_stage
            // Operand skew: slice g reads its bits g+1 edges after sampling.
            gcla_delay #(.W(GROUP_W), .DEPTH(g + 1)) u_dly_a (
                .clk (clk), .rst_n (rst_n),
                .d   (op_a[g*GROUP_W +: GROUP_W]),
                .q   (grp_a[g])
            );
            gcla_delay #(.W(GROUP_W), .DEPTH(g + 1)) u_dly_b (
                .clk (clk), .rst_n (rst_n),
                .d   (op_b[g*GROUP_W +: GROUP_W]),
                .q   (grp_b[g])
            );
            // Carry into slice g: registered once so it meets the skewed operands.
            if (g == 0) begin : g_cin_head
                gcla_delay #(.W(1), .DEPTH(1)) u_dly_c (
                    .clk (clk), .rst_n (rst_n),
                    .d   (carry_in),
                    .q   (grp_cin[g])
                );
            end else begin : g_cin_link
                gcla_delay #(.W(1), .DEPTH(1)) u_dly_c (
                    .clk (clk), .rst_n (rst_n),
                    .d   (grp_cout[g-1]),
                    .q   (grp_cin[g])
                );
            end
            // Sum deskew: slice g result waits NUM_GROUPS-g edges to the output.
            gcla_delay #(.W(GROUP_W), .DEPTH(NUM_GROUPS - g)) u_dly_s (
                .clk (clk), .rst_n (rst_n),
                .d   (grp_s[g]),
                .q   (sum[g*GROUP_W +: GROUP_W])
            );
        end

        // Final carry registered alongside the top slice sum.
        gcla_delay #(.W(1), .DEPTH(1)) u_dly_cout (
            .clk (clk), .rst_n (rst_n),
            .d   (grp_cout[NUM_GROUPS-1]),
            .q   (carry_out)
        );

        // Valid flag travels the full depth of the sum path.
        gcla_delay #(.W(1), .DEPTH(LAT + 1)) u_dly_valid (
            .clk (clk), .rst_n (rst_n),
            .d   (in_valid),
            .q   (out_valid)
        );
    end else begin : g_comb
        for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_link
            assign grp_a[g] = op_a[g*GROUP_W +: GROUP_W];
            assign grp_b[g] = op_b[g*GROUP_W +: GROUP_W];
            assign sum[g*GROUP_W +: GROUP_W] = grp_s[g];
            if (g == 0) begin : g_head
                assign grp_cin[g] = carry_in;
            end else begin : g_ripple
                assign grp_cin[g] = grp_cout[g-1];
            end
        end
        assign carry_out = grp_cout[NUM_GROUPS-1];
        assign out_valid = in_valid;
    end

endmodule

// File: rtl/gcla_checker.sv
// Property checker for grouped_cla_adder, attached by bind.
// Keeps its own arithmetic model of each accepted pair and its own timing pipe.
module gcla_checker #(
    parameter int unsigned GROUP_W    = 4,
    parameter int unsigned NUM_GROUPS = 4,
    parameter bit          REGISTERED = 1'b1
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          in_valid,
    input logic [GROUP_W*NUM_GROUPS-1:0] op_a,
    input logic [GROUP_W*NUM_GROUPS-1:0] op_b,
    input logic                          carry_in,
    input logic [GROUP_W*NUM_GROUPS-1:0] sum,
    input logic                          carry_out,
    input logic                          out_valid
);

    localparam int unsigned W     = GROUP_W * NUM_GROUPS;
    localparam int unsigned DEPTH = NUM_GROUPS + 1;
    localparam logic [W:0]  MAX_U = {1'b0, {W{1'b1}}};

    logic [W:0] total_now;
    assign total_now = {1'b0, op_a} + {1'b0, op_b} + {{W{1'b0}}, carry_in};

    if (REGISTERED) begin : g_chk_pipe
        logic       vld_q [DEPTH];
        logic [W:0] tot_q [DEPTH];

        // Model pipe: the arithmetic total of each sampled pair.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int i = 0; i < DEPTH; i++) begin
                    vld_q[i] <= 1'b0;
                    tot_q[i] <= '0;
                end
            end else begin
                vld_q[0] <= in_valid;
                tot_q[0] <= total_now;
                for (int i = 1; i < DEPTH; i++) begin
                    vld_q[i] <= vld_q[i-1];
                    tot_q[i] <= tot_q[i-1];
                end
            end
        end

        a_r1_total_matches: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> ({carry_out, sum} == tot_q[DEPTH-1]));

        a_r2_overflow_flag: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> (carry_out == (tot_q[DEPTH-1] > MAX_U)));

        a_r6_valid_timing: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid == vld_q[DEPTH-1]);

        a_r7_reset_clears: assert property (@(posedge clk)
            !rst_n |=> (!out_valid && (sum == '0) && !carry_out));
    end else begin : g_chk_comb
        a_r1_total_matches: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |-> ({carry_out, sum} == total_now));

        a_r2_overflow_flag: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |-> (carry_out == (total_now > MAX_U)));

        a_r6_valid_timing: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid == in_valid);

        a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |-> !out_valid);
    end

endmodule

bind grouped_cla_adder gcla_checker #(
    .GROUP_W    (GROUP_W),
    .NUM_GROUPS (NUM_GROUPS),
    .REGISTERED (REGISTERED)
) u_gcla_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_a      (op_a),
    .op_b      (op_b),
    .carry_in  (carry_in),
    .sum       (sum),
    .carry_out (carry_out),
    .out_valid (out_valid)
);

// File: tb/grouped_cla_adder_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: a driver task queues the expected total and issue edge
// of each pair; a monitor pops and compares whenever out_valid is seen.
module grouped_cla_adder_tb;

    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 4;     // edges from sampling to result (R6)
    localparam int WATCHDOG   = 20000;

    typedef struct {
        logic [16:0] total;
        int          issue;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] op_a = '0;
    logic [15:0] op_b = '0;
    logic        carry_in = 1'b0;
    logic [15:0] sum;
    logic        carry_out;
    logic        out_valid;

    int    cyc = 0;
    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    item_t sb_q[$];
    logic [31:0] rng = 32'h1234_5678;

    grouped_cla_adder u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .op_a      (op_a),
        .op_b      (op_b),
        .carry_in  (carry_in),
        .sum       (sum),
        .carry_out (carry_out),
        .out_valid (out_valid)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] next_rng(input logic [31:0] s);
        logic [31:0] x;
        x = s ^ (s << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Driver: present one valid pair and queue its expected result.
    task automatic issue(input logic [15:0] a, input logic [15:0] b,
                         input logic c, input string tag);
        item_t it;
        @(negedge clk);
        in_valid = 1'b1;
        op_a = a;
        op_b = b;
        carry_in = c;
        it.total = {1'b0, a} + {1'b0, b} + {16'd0, c};
        it.issue = cyc + 1;
        it.tag   = tag;
        sb_q.push_back(it);
    endtask

    // Driver: an idle cycle with junk operands (R8).
    task automatic idle();
        @(negedge clk);
        rng = next_rng(rng);
        in_valid = 1'b0;
        op_a = rng[15:0];
        op_b = rng[31:16];
        carry_in = rng[3];
    endtask

    // Monitor: compare each result with the oldest queued pair.
    always @(negedge clk) begin
        if (rst_n && out_valid && !done) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R8 unexpected out_valid", 32'd1, 32'd0);
            end else begin
                item_t it;
                it = sb_q.pop_front();
                check({carry_out, sum} == it.total, {it.tag, " R1 total"},
                      {15'd0, carry_out, sum}, {15'd0, it.total});
                check(cyc - it.issue == LAT, {it.tag, " R6 latency"},
                      cyc - it.issue, LAT);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog actual=expired expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R7: reset with valid junk on the inputs keeps outputs cleared.
        in_valid = 1'b1;
        op_a = 16'hBEEF;
        op_b = 16'hCAFE;
        repeat (3) @(negedge clk);
        check(!out_valid && sum == 16'h0 && !carry_out, "R7 reset state",
              {15'd0, out_valid, sum}, 32'd0);
        in_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;

        // Directed corners, back to back so slice carries overlap in time.
        issue(16'h0000, 16'h0000, 1'b0, "R4 zero plus zero");
        issue(16'hFFFF, 16'h0000, 1'b1, "R3 full propagate");
        issue(16'h0000, 16'h0000, 1'b1, "R9 carry_in at lsb");
        issue(16'h8000, 16'h8000, 1'b0, "R2 overflow top bit");
        issue(16'hFFFF, 16'hFFFF, 1'b1, "R2 overflow all ones");
        issue(16'h000F, 16'h0001, 1'b0, "R5 slice0 to slice1");
        issue(16'h00FF, 16'h0001, 1'b0, "R5 slice1 to slice2");
        issue(16'h0FFF, 16'h0001, 1'b0, "R5 slice2 to slice3");
        issue(16'h7FFF, 16'h0000, 1'b1, "R5 carry stops at msb");
        idle();
        idle();

        // Pseudo-random pairs with idle gaps (R1, R6, R8).
        for (int n = 0; n < 60; n++) begin
            rng = next_rng(rng);
            issue(rng[15:0], rng[31:16], rng[7], "R1 random");
            if (rng[9] && rng[4]) idle();
        end
        repeat (LAT + 3) idle();

        // R7: reset while two pairs are in flight; they must never appear.
        issue(16'h1234, 16'h4321, 1'b0, "R7 dropped");
        issue(16'hFFFF, 16'h0001, 1'b0, "R7 dropped");
        @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b0;
        sb_q.delete();
        @(negedge clk);
        rst_n = 1'b1;
        for (int n = 0; n < LAT + 3; n++) begin
            @(negedge clk);
            check(!out_valid, "R7 in-flight pair dropped", {31'd0, out_valid}, 32'd0);
        end

        // Normal operation resumes after the reset.
        issue(16'hFFFF, 16'h0000, 1'b1, "R3 after reset");
        issue(16'h0000, 16'h0000, 1'b0, "R4 after reset");
        repeat (LAT + 4) idle();

        // R6: every accepted pair produced exactly one result.
        check(sb_q.size() == 0, "R6 all results delivered", sb_q.size(), 32'd0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule